// File: doc/BRIEF.md
# Ripple-Carry Arithmetic Logic Unit with Signed Compare

This block is a purely combinational arithmetic logic unit. It is built as a chain of identical one-bit slices that share their control lines. Each slice holds an AND gate, an OR gate, a full adder, an optional inverter on each operand and an output multiplexer. Carries ripple from bit 0 upward.

A 4-bit control word picks the operation: AND, OR, NOR, addition, subtraction or signed set-on-less-than. It does so by setting the operand inversions and the output selector. The operand-B inversion line also serves as the carry into bit 0, so subtraction is formed as A + ~B + 1 without a separate carry input.

For set-on-less-than, the slices run the subtraction. The most significant slice reports the corrected sign of the difference, and that value is fed back into the "less" input of bit 0. Every other slice receives a constant 0 on its "less" input. The unit has no clock or handshake: operands and control word go in, and result and flags settle after the ripple delay. It is meant to sit between the operand registers and the writeback registers of a datapath.

Top module: `ripple_alu`

## Requirements
- R1: The control word is laid out as {a_invert, b_invert, op[1:0]}. The op field selects the slice output: 00 selects AND, 01 selects OR, 10 selects the adder sum and 11 selects the less input. With control 0000 the result is A & B.
- R2: With control 0001 the result is A | B.
- R3: With control 0010 the result is A + B modulo 2^32, and carry_out is the carry out of bit 31 of that addition.
- R4: With control 0110 the result is A - B, computed as A + ~B + 1. carry_out is the carry out of bit 31 of that sum, which is 1 exactly when A >= B as unsigned values.
- R5: With control 0111, bits 31..1 of the result are 0, and bit 0 is 1 exactly when A < B as signed two's-complement values. This holds even when A - B overflows.
- R6: With control 1100 the result is ~A & ~B, which equals ~(A | B).
- R7: zero is 1 exactly when all 32 result bits are 0, for every control word.
- R8: For every control word, overflow is the XOR of the carry into and the carry out of bit 31 of the adder. The adder computes A' + B' + b_invert, where A' and B' are the operands after the selected inversions. carry_out is the carry out of bit 31 of the same sum.
- R9: Under addition (control 0010), operands whose bit 31 differs never raise overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| ctrl | input | 4 | {a_invert, b_invert, op[1:0]} |
| result | output | 32 | Selected slice outputs |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of the adder |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
Whenever the inputs change, the assertions check the following. The addition and subtraction results against the arithmetic operators. The AND result. The cleared upper bits under set-on-less-than. The agreement of the zero flag with the result. The absence of overflow on mixed-sign additions. Only the bench scenarios can show the rest: that the compare bit gives the true signed ordering when the difference overflows, that NOR is produced by the inversion path, and that the flags are correct on the corner operands 0, -1, the most positive value and the most negative value.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  localparam logic [3:0] CTL_AND = 4'b0000;
  localparam logic [3:0] CTL_OR  = 4'b0001;
  localparam logic [3:0] CTL_ADD = 4'b0010;
  localparam logic [3:0] CTL_SUB = 4'b0110;
  localparam logic [3:0] CTL_SLT = 4'b0111;
  localparam logic [3:0] CTL_NOR = 4'b1100;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       a_inv,
  input  logic       b_inv,
  input  logic       cin,
  input  logic       less,
  input  slice_sel_e sel,
  output logic       res,
  output logic       sum,
  output logic       cout
);
  logic a_eff, b_eff, and_o, or_o;

  // operand inverters
  assign a_eff = a ^ a_inv;
  assign b_eff = b ^ b_inv;

  // logic gates
  assign and_o = a_eff & b_eff;
  assign or_o  = a_eff | b_eff;

  // full adder
  assign sum  = a_eff ^ b_eff ^ cin;
  assign cout = (a_eff & b_eff) | (cin & (a_eff ^ b_eff));

  // output multiplexer
  always_comb begin
    unique case (sel)
      SEL_AND:  res = and_o;
      SEL_OR:   res = or_o;
      SEL_SUM:  res = sum;
      default:  res = less;
    endcase
  end
endmodule

// File: rtl/alu_zero_nor.sv
module alu_zero_nor #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec,
  output logic             is_zero
);
  assign is_zero = ~(|vec);
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carry_out
);
  localparam int MSB = WIDTH - 1;

  logic             a_inv, b_inv;
  slice_sel_e       sel;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum_w;
  logic [WIDTH-1:0] less_w;
  logic             set_bit;

  assign a_inv    = ctrl[3];
  assign b_inv    = ctrl[2];
  assign sel      = slice_sel_e'(ctrl[1:0]);
  assign carry[0] = b_inv;   // the invert line doubles as first carry-in

  // overflow from the top slice, corrected sign feeds back to bit 0
  assign overflow  = carry[MSB] ^ carry[WIDTH];
  assign carry_out = carry[WIDTH];
  assign set_bit   = sum_w[MSB] ^ overflow;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      if (i == 0) begin : g_lsb
        assign less_w[i] = set_bit;
      end else begin : g_upper
        assign less_w[i] = 1'b0;
      end
      alu_bit_slice u_slice (
        .a     (a[i]),
        .b     (b[i]),
        .a_inv (a_inv),
        .b_inv (b_inv),
        .cin   (carry[i]),
        .less  (less_w[i]),
        .sel   (sel),
        .res   (result[i]),
        .sum   (sum_w[i]),
        .cout  (carry[i+1])
      );
    end
  endgenerate

  alu_zero_nor #(.WIDTH(WIDTH)) u_zero (
    .vec     (result),
    .is_zero (zero)
  );

  always_comb begin
    if (ctrl == CTL_AND) AST_AND_RESULT: assert (result == (a & b)); // R1
    if (ctrl == CTL_ADD) AST_ADD_SUM: assert ({carry_out, result} == ({1'b0, a} + {1'b0, b}) && result == sum_w); // R3
    if (ctrl == CTL_SUB) AST_SUB_DIFF: assert (result == a - b); // R4
    if (sel == SEL_LESS) AST_SLT_UPPER_ZERO: assert (result[MSB:1] == '0); // R5
    AST_ZERO_FLAG: assert (zero == (result == '0)); // R7
    if (ctrl == CTL_ADD && (a[MSB] != b[MSB])) AST_NO_OVERFLOW: assert (!overflow); // R9
  end
endmodule

// File: tb/test_ripple_alu.sv
module test_ripple_alu;
  logic        clk = 1'b0;
  logic [31:0] a, b, result;
  logic [3:0]  ctrl;
  logic        zero, overflow, carry_out;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ripple_alu i_ripple_alu (
    .a(a), .b(b), .ctrl(ctrl),
    .result(result), .zero(zero), .overflow(overflow), .carry_out(carry_out)
  );

  // expected {result, zero, overflow, carry_out}
  function automatic logic [34:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic [3:0] c);
    logic [31:0] xa, yb, r;
    logic [32:0] s;
    logic ov;
    xa = c[3] ? ~x : x;
    yb = c[2] ? ~y : y;
    s  = {1'b0, xa} + {1'b0, yb} + {32'd0, c[2]};
    ov = (xa[31] == yb[31]) && (s[31] != xa[31]);
    case (c[1:0])
      2'b00: r = xa & yb;
      2'b01: r = xa | yb;
      2'b10: r = s[31:0];
      default: r = {31'd0, s[31] ^ ov};
    endcase
    return {r, (r == 32'd0), ov, s[32]};
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [3:0] c);
    logic [34:0] e;
    @(negedge clk);
    a = x; b = y; ctrl = c;
    #2;
    e = model(x, y, c);
    n_run++;
    if (result !== e[34:3]) begin
      n_fail++;
      $display("FAIL %s result a=%h b=%h ctl=%b got %h exp %h", req_of(c), x, y, c, result, e[34:3]);
    end
    n_run++;
    if (zero !== e[2]) begin
      n_fail++;
      $display("FAIL R7 zero a=%h b=%h ctl=%b got %b exp %b", x, y, c, zero, e[2]);
    end
    n_run++;
    if ({overflow, carry_out} !== e[1:0]) begin
      n_fail++;
      $display("FAIL R8 flags a=%h b=%h ctl=%b got %b exp %b", x, y, c, {overflow, carry_out}, e[1:0]);
    end
  endtask

  logic [31:0] corners [6] = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1, 32'h2};
  logic [3:0]  ops     [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};

  initial begin
    a = '0; b = '0; ctrl = '0;
    void'($urandom(32'd20240611));
    // directed corners over every operation (R1..R8)
    foreach (ops[k]) foreach (corners[i]) foreach (corners[j])
      apply(corners[i], corners[j], ops[k]);
    // R5: compare across an overflowing subtraction
    apply(32'h8000_0000, 32'h0000_0001, 4'b0111);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
    // R9: mixed-sign addition
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'b0010);
    // R7: equal operands subtract to zero
    apply(32'h1234_5678, 32'h1234_5678, 4'b0110);
    // random operands, listed and arbitrary control words
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] c;
      c = (n % 4 == 3) ? 4'($urandom) : ops[$urandom % 6];
      apply($urandom, $urandom, c);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule